// File: doc/BRIEF.md
# Two-Phase ADD/NOR Execution Core

This block is a 16-bit execution core in which every instruction takes two clock cycles: an execute phase and then a fetch phase. In the execute phase the arithmetic unit forms either a sum or a bitwise NOR. The result goes into a holding stage. A store instruction instead drives a data register onto the memory port. In the fetch phase the held result is written to its destination register, shifted right by one bit if the instruction asks for it. In the same phase the next instruction word is read from the address in A0 and latched.

The core holds four data registers (D0..D3) and four address registers (A0..A3). A0 is the program counter. The arithmetic unit has only two operations, and the remaining moves are built from them. A move is a sum with a zero first operand. A complemented move is a NOR with a zero first operand. A shift left comes for free as a side effect of every store, because the stored register is added to itself and written back.

Memory is a plain byte-addressed port with one request per cycle. The read data is expected in the same cycle as the request. Words sit at even addresses. Interrupts, branches and condition flags do not exist; writing A0 is the only way to change the flow of the program.

Top module: `duo_phase_core`

## Requirements
- R1: After reset is released the core is in the fetch phase with memAddr 0x0000, memRd high and memWr low. After that, execute and fetch phases alternate every cycle.
- R2: In every fetch phase the word read at address A0 becomes the next instruction and A0 advances by 2. If the pending result targets A0, then A0 takes that result instead, and the fetch in that same phase still uses the old A0.
- R3: Instruction format. Bits[15:14] give the kind: 00 is an immediate operand (bits[7:0] zero-extended), 01 is an address-register operand (A[bits1:0]), 10 is a memory operand at A[bits5:4] + 2*bits[3:0], and 11 is a store. For the three computing kinds, bit13 selects NOR (1) or ADD (0), bit12 replaces the first operand with zero, bit11 requests the shift, bit10 selects an address-register destination, and bits[9:8] give the destination index.
- R4: ADD produces first operand + operand modulo 2^16, where the first operand is the current value of the destination register. With bit12 set this is a plain move.
- R5: NOR produces ~(first operand | operand). With bit12 set this is a complemented move.
- R6: A NOR whose destination is an address register writes no register.
- R7: With bit11 set, the value written back is the result shifted right logically by one bit, with a zero shifted in at the top.
- R8: A store drives memWr high during its execute phase, with memAddr = A[bits5:4] + 2*bits[3:0] and the source D[bits9:8]. When bit13 is 0 it is a word store: memByte is low and memWdata is the whole register. When bit13 is 1 it is a byte store: memByte is high and memWdata carries the low byte with the upper byte zero.
- R9: After a store, the source data register holds twice its old value, modulo 2^16, unshifted.
- R10: A memory-operand instruction raises memRd in its execute phase and consumes memRdata in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memRdata | input | 16 | Read data, valid in the same cycle as the request |
| memAddr | output | 16 | Byte address |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memByte | output | 1 | Write covers the low byte only |
| memWdata | output | 16 | Write data |

## Verification
The assertions take for granted that memRdata is settled in the same cycle as every read request. They also assume that no instruction stream wraps A0 past the top of the address space. The stimulus keeps within these limits with a combinational memory model and a short program that ends in a tight self-jump. All observation happens through store traffic on the memory port: every register effect (the move, the complement, the shift, the suppressed NOR and the doubling after a store) is made visible by a later store and compared in order against expected writes.

// File: rtl/duo_phase_pkg.sv
package duo_phase_pkg;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'b00,
    SRC_AREG = 2'b01,
    SRC_MEM  = 2'b10,
    SRC_DREG = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic       isFetch;
    logic       aluNor;
    logic       clrFirst;
    logic       shiftOut;
    logic       dstAddr;
    logic [1:0] dstIdx;
    srcSel_e    srcSel;
    logic [1:0] srcIdx;
    logic [1:0] addrIdx;
    logic [3:0] disp;
    logic [7:0] imm;
    logic       store;
    logic       storeByte;
  } strobe_t;

endpackage

// File: rtl/duo_phase_ctrl.sv
module duo_phase_ctrl
  import duo_phase_pkg::*;
#(
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DataW-1:0] memRdata,
  output strobe_t          strobes
);

  logic        isFetchQ;
  logic [15:0] instrQ;
  logic [1:0]  kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      isFetchQ <= 1'b1;
      instrQ   <= '0;
    end else begin
      isFetchQ <= ~isFetchQ;
      if (isFetchQ) instrQ <= memRdata[15:0];
    end
  end

  assign kind = instrQ[15:14];

  always_comb begin
    strobes.isFetch   = isFetchQ;
    strobes.dstIdx    = instrQ[9:8];
    strobes.srcIdx    = instrQ[1:0];
    strobes.addrIdx   = instrQ[5:4];
    strobes.disp      = instrQ[3:0];
    strobes.imm       = instrQ[7:0];
    if (kind == 2'b11) begin
      strobes.store     = 1'b1;
      strobes.storeByte = instrQ[13];
      strobes.aluNor    = 1'b0;
      strobes.clrFirst  = 1'b0;
      strobes.shiftOut  = 1'b0;
      strobes.dstAddr   = 1'b0;
      strobes.srcSel    = SRC_DREG;
    end else begin
      strobes.store     = 1'b0;
      strobes.storeByte = 1'b0;
      strobes.aluNor    = instrQ[13];
      strobes.clrFirst  = instrQ[12];
      strobes.shiftOut  = instrQ[11];
      strobes.dstAddr   = instrQ[10];
      strobes.srcSel    = srcSel_e'(kind);
    end
  end

endmodule

// File: rtl/duo_phase_dp.sv
module duo_phase_dp
  import duo_phase_pkg::*;
#(
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [DataW-1:0] memRdata,
  output logic [DataW-1:0] memAddr,
  output logic             memRd,
  output logic             memWr,
  output logic             memByte,
  output logic [DataW-1:0] memWdata
);

  localparam int RegCount = 4;
  localparam int IdxW     = $clog2(RegCount);
  localparam logic [DataW-1:0] PcStep = DataW'(2);

  logic [DataW-1:0] dReg [RegCount];
  logic [DataW-1:0] aReg [RegCount];

  logic [DataW-1:0] holdVal;
  logic             holdWr;
  logic             holdShift;
  logic             holdDstAddr;
  logic [IdxW-1:0]  holdIdx;

  logic [DataW-1:0] firstOp, secondOp, aluRes, wbVal, effAddr, immExt, dispExt;
  logic             pcLoad;

  assign immExt  = {{(DataW-8){1'b0}}, strobes.imm};
  assign dispExt = {{(DataW-5){1'b0}}, strobes.disp, 1'b0};
  assign effAddr = aReg[strobes.addrIdx] + dispExt;

  assign memAddr  = strobes.isFetch ? aReg[0] : effAddr;
  assign memRd    = strobes.isFetch || (!strobes.store && strobes.srcSel == SRC_MEM);
  assign memWr    = !strobes.isFetch && strobes.store;
  assign memByte  = memWr && strobes.storeByte;
  assign memWdata = strobes.storeByte ? {{(DataW-8){1'b0}}, dReg[strobes.dstIdx][7:0]}
                                      : dReg[strobes.dstIdx];

  always_comb begin
    case (strobes.srcSel)
      SRC_IMM:  secondOp = immExt;
      SRC_AREG: secondOp = aReg[strobes.srcIdx];
      SRC_MEM:  secondOp = memRdata;
      default:  secondOp = dReg[strobes.dstIdx];
    endcase
    if (strobes.clrFirst)     firstOp = '0;
    else if (strobes.dstAddr) firstOp = aReg[strobes.dstIdx];
    else                      firstOp = dReg[strobes.dstIdx];
    aluRes = strobes.aluNor ? ~(firstOp | secondOp) : firstOp + secondOp;
  end

  assign wbVal  = holdShift ? {1'b0, holdVal[DataW-1:1]} : holdVal;
  assign pcLoad = holdWr && holdDstAddr && (holdIdx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RegCount; i++) begin
        dReg[i] <= '0;
        aReg[i] <= '0;
      end
      holdVal     <= '0;
      holdWr      <= 1'b0;
      holdShift   <= 1'b0;
      holdDstAddr <= 1'b0;
      holdIdx     <= '0;
    end else if (!strobes.isFetch) begin
      holdVal     <= aluRes;
      holdShift   <= strobes.shiftOut;
      holdDstAddr <= strobes.dstAddr;
      holdIdx     <= strobes.dstIdx;
      holdWr      <= !(strobes.aluNor && strobes.dstAddr);
    end else begin
      holdWr <= 1'b0;
      if (holdWr && !holdDstAddr) dReg[holdIdx] <= wbVal;
      if (holdWr && holdDstAddr && holdIdx != '0) aReg[holdIdx] <= wbVal;
      aReg[0] <= pcLoad ? wbVal : aReg[0] + PcStep;
    end
  end

  // R1: the phase strobe toggles every cycle
  a_r1_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    strobes.isFetch |=> !strobes.isFetch);
  a_r1_phase_return: assert property (@(posedge clk) disable iff (rst)
    !strobes.isFetch |=> strobes.isFetch);

  // R2: the program counter steps by two unless it is the destination
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.isFetch && !pcLoad) |=> aReg[0] == $past(aReg[0]) + PcStep);

  // R6: a NOR aimed at an address register leaves nothing to write
  a_r6_nor_addr_blocked: assert property (@(posedge clk) disable iff (rst)
    (!strobes.isFetch && strobes.aluNor && strobes.dstAddr) |=> !holdWr);

  // R9: a word store leaves twice the stored value pending
  a_r9_store_doubles: assert property (@(posedge clk) disable iff (rst)
    (memWr && !memByte) |=> holdVal == DataW'($past(memWdata) << 1));

  // R8: stores never coincide with a read request
  a_r8_store_no_read: assert property (@(posedge clk) disable iff (rst)
    memWr |-> !memRd);

endmodule

// File: rtl/duo_phase_core.sv
module duo_phase_core
  import duo_phase_pkg::*;
#(
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DataW-1:0] memRdata,
  output logic [DataW-1:0] memAddr,
  output logic             memRd,
  output logic             memWr,
  output logic             memByte,
  output logic [DataW-1:0] memWdata
);

  strobe_t strobes;

  duo_phase_ctrl #(.DataW(DataW)) ctrl_i (
    .clk(clk), .rst(rst), .memRdata(memRdata), .strobes(strobes)
  );

  duo_phase_dp #(.DataW(DataW)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memByte(memByte), .memWdata(memWdata)
  );

endmodule

// File: tb/duo_phase_core_tb_top.sv
`timescale 1ns/1ps
module duo_phase_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memRdata, memAddr, memWdata;
  logic        memRd, memWr, memByte;

  logic [15:0] mem [128];

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    logic        isByte;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  duo_phase_core dut_i (
    .clk(clk), .rst(rst), .memRdata(memRdata), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memByte(memByte), .memWdata(memWdata)
  );

  assign memRdata = mem[memAddr[7:1]];

  always @(posedge clk) begin
    if (!rst && memWr) begin
      if (memByte) mem[memAddr[7:1]][7:0] <= memWdata[7:0];
      else         mem[memAddr[7:1]]      <= memWdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic pushExp(input logic [15:0] a, input logic [15:0] d, input logic b, input string tag);
    expItem_t it;
    it.addr = a; it.data = d; it.isByte = b; it.tag = tag;
    expQ.push_back(it);
  endtask

  function automatic logic [15:0] enc(input logic [1:0] kind, input logic nor_, input logic clr,
                                      input logic sh, input logic dA, input logic [1:0] dst,
                                      input logic [7:0] low);
    return {kind, nor_, clr, sh, dA, dst, low};
  endfunction

  function automatic logic [15:0] st(input logic byteSel, input logic [1:0] src,
                                     input logic [1:0] areg, input logic [3:0] disp);
    return {2'b11, byteSel, 3'b000, src, 2'b00, areg, disp};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && memWr) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected store", {memAddr, memWdata}, 32'hFFFF_FFFF);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.tag, " addr"}, {16'h0, memAddr}, {16'h0, it.addr});
        check({it.tag, " data/byte"}, {15'h0, memByte, memWdata}, {15'h0, it.isByte, it.data});
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    mem[0]  = enc(2'b00, 0, 1, 0, 1, 2'd1, 8'h80);       // MOV A1,#80
    mem[1]  = enc(2'b00, 0, 1, 0, 0, 2'd0, 8'h12);       // MOV D0,#12
    mem[2]  = enc(2'b00, 0, 0, 0, 0, 2'd0, 8'h05);       // ADD D0,#05
    mem[3]  = st(0, 2'd0, 2'd1, 4'd0);
    mem[4]  = st(0, 2'd0, 2'd1, 4'd1);
    mem[5]  = enc(2'b00, 1, 1, 0, 0, 2'd1, 8'h0F);       // MOVC D1,#0F
    mem[6]  = st(0, 2'd1, 2'd1, 4'd2);
    mem[7]  = enc(2'b00, 1, 0, 0, 0, 2'd1, 8'h01);       // NOR D1,#01
    mem[8]  = st(1, 2'd1, 2'd1, 4'd3);
    mem[9]  = enc(2'b00, 0, 1, 1, 0, 2'd2, 8'hF1);       // MOV D2,#F1 shifted
    mem[10] = st(0, 2'd2, 2'd1, 4'd4);
    mem[11] = enc(2'b00, 0, 1, 0, 1, 2'd2, 8'h33);       // MOV A2,#33
    mem[12] = enc(2'b00, 1, 0, 0, 1, 2'd2, 8'h00);       // NOR A2 -> no write
    mem[13] = enc(2'b01, 0, 1, 0, 0, 2'd3, 8'h02);       // MOV D3,A2
    mem[14] = st(0, 2'd3, 2'd1, 4'd5);
    mem[15] = enc(2'b10, 0, 1, 0, 0, 2'd0, 8'h10);       // MOV D0,[A1+0]
    mem[16] = enc(2'b10, 0, 0, 0, 0, 2'd0, 8'h12);       // ADD D0,[A1+2]
    mem[17] = st(0, 2'd0, 2'd1, 4'd6);
    mem[18] = enc(2'b00, 0, 0, 0, 1, 2'd1, 8'h10);       // ADD A1,#10
    mem[19] = st(0, 2'd0, 2'd1, 4'd0);
    mem[20] = enc(2'b00, 0, 1, 0, 1, 2'd0, 8'h40);       // MOV A0,#40
    mem[21] = st(0, 2'd0, 2'd1, 4'd1);
    mem[22] = st(0, 2'd3, 2'd1, 4'd2);                   // must be skipped
    mem[32] = st(0, 2'd0, 2'd1, 4'd3);
    mem[33] = enc(2'b00, 0, 1, 0, 1, 2'd0, 8'h42);       // MOV A0,#42
    mem[34] = enc(2'b00, 1, 0, 0, 1, 2'd3, 8'h00);       // no-op
    mem[67] = 16'hAB00;

    pushExp(16'h0080, 16'h0017, 0, "R4 add after move");
    pushExp(16'h0082, 16'h002E, 0, "R9 doubled after store");
    pushExp(16'h0084, 16'hFFF0, 0, "R5 complemented move");
    pushExp(16'h0086, 16'h001E, 1, "R8 byte store of NOR");
    pushExp(16'h0088, 16'h0078, 0, "R7 shifted move");
    pushExp(16'h008A, 16'h0033, 0, "R6 R3 suppressed NOR, areg operand");
    pushExp(16'h008C, 16'h0007, 0, "R10 memory operand add wraps");
    pushExp(16'h0090, 16'h000E, 0, "R4 add to address register");
    pushExp(16'h0092, 16'h001C, 0, "R2 word after A0 write runs");
    pushExp(16'h0096, 16'h0038, 0, "R2 A0 write redirects fetch");

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #0.5;
    check("R1 reset addr", {16'h0, memAddr}, 32'h0);
    check("R1 reset rd/wr", {30'h0, memRd, memWr}, 32'h2);
    @(negedge clk);
    check("R1 execute after fetch", {31'h0, memRd}, 32'h0);

    repeat (200) @(posedge clk);
    @(negedge clk);
    check("R2 all expected stores seen", expQ.size(), 0);
    check("R8 byte store keeps upper byte", {16'h0, mem[67]}, 32'h0000_AB1E);
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule